// File: doc/BRIEF.md
# Reference-Disciplined Tick Multiplier

This block turns a slow reference pulse into a train of single-cycle ticks at a fixed multiple of its rate, ten ticks per reference interval by default. One free-running counter serves two purposes. It is the time base of a digitally controlled oscillator: a compare value is moved forward by the current period each time the counter reaches it. It also timestamps every reference rising edge.

The reference first passes through a synchroniser and a rising-edge detector. A captured edge is used only if it falls near the tick whose index is 0, either in the interval just before that tick or the one just after it. The block subtracts the compare time of that tick from the timestamp, modulo the counter width, which gives a signed phase error. A late reference gives a positive error, which means the ticks run fast, so the period is made longer. A tiered law turns the error into a period change. The thresholds are expressed in counts of tenth-tick phase, and the steps in counts of per-tick period, because one count of period moves the tenth tick by ten counts.

The period register is kept between a lower and an upper bound. A lock flag reports a run of phase errors that stayed inside the deadband.

Top module: `tick_mult`

## Requirements
- R1: While reset is held and immediately after it, tick_o is 0, tick_idx_o is 0, period_o equals NOM_PERIOD (500) and lock_o is 0.
- R2: The first tick comes exactly NOM_PERIOD cycles after reset is released. Each later tick comes exactly P cycles after the previous one, where P is the value period_o showed in the cycle of that previous tick.
- R3: In its tick cycle, tick_idx_o carries the tick's index. The first tick is index 0, and the index counts up by one per tick and wraps from TICKS-1 (9) to 0.
- R4: The reference is synchronised through two flops and only its rising edges count. The timestamp of an edge is the counter value two cycles after the sampling edge that first sees the input high. The phase error e is the timestamp minus the compare time of the index-0 tick, as a signed value modulo the counter width. The edge is used only if tick_idx_o is 0 or 1 in the capture cycle: index 0 compares against the tick about to come, index 1 against the tick just gone.
- R5: When |e| <= 4 (deadband), the period is unchanged.
- R6: When 4 < |e| <= 80, the period changes by 1 in the direction of the sign of e (positive e makes it longer).
- R7: When 80 < |e| <= 400, the period changes by floor(floor(|e|/8)/TICKS) in the direction of the sign of e. For example, e = -200 gives -2 and e = +400 gives +5.
- R8: When |e| > 400, the period changes by 6 in the direction of the sign of e, and lock_o is cleared.
- R9: A rising edge captured while tick_idx_o is neither 0 nor 1 changes neither period_o nor lock_o.
- R10: period_o never leaves the range 480 to 520. A correction that would pass a bound stops at that bound.
- R11: lock_o rises when LOCK_N (3) used edges in a row fall inside the deadband. Any used edge outside the deadband restarts that count. Minor and moderate errors leave lock_o as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Slow reference pulse, asynchronous |
| tick_o | output | 1 | Single-cycle tick pulse |
| tick_idx_o | output | $clog2(TICKS) | Index of the current or next tick |
| period_o | output | CNT_W | Current per-tick period in cycles |
| lock_o | output | 1 | Phase held inside the deadband |

## Verification
The bench places reference edges at chosen offsets from the index-0 tick. It works these out from the observed tick train and the known synchroniser latency, so each offset lands on a known side of every tier boundary: 4 against 30, 80 against 200, 400 against 450. It uses both signs, early and late. If the sign were inverted, or the prediction came from the wrong tick, the period would move the wrong way. If the ten-fold scaling were missing, a moderate error would give a step roughly ten times too large.

An edge placed mid-interval must leave the period and the lock flag untouched. Repeated gross errors must pin the period at each bound rather than let it overshoot or wrap. The lock check looks for lock on exactly the third deadband edge, lock kept through moderate errors, and lock dropped on a gross one. A design with an off-by-one in the lock count, or one that cleared lock on every correction, fails here.

// File: rtl/tick_pkg.sv
package tick_pkg;
    typedef enum logic [1:0] {
        TIER_DEAD  = 2'd0,
        TIER_MINOR = 2'd1,
        TIER_MID   = 2'd2,
        TIER_GROSS = 2'd3
    } tier_e;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], ref_i};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sh[STAGES-1] & ~s_q.prev;

    // R4: a held-high reference yields exactly one capture strobe
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tick_dco.sv
module tick_dco #(
    parameter int CNT_W      = 16,
    parameter int TICKS      = 10,
    parameter int NOM_PERIOD = 500,
    localparam int IDX_W     = $clog2(TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic             tick_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic [CNT_W-1:0] pred_o,
    output logic             win_o
);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] NOM      = CNT_W'(NOM_PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] anchor;
        logic [IDX_W-1:0] idx;
    } dco_t;

    dco_t o_d, o_q;
    logic hit;

    assign hit = (o_q.cnt == o_q.cmp);

    always_comb begin
        o_d     = o_q;
        o_d.cnt = o_q.cnt + CNT_ONE;
        if (hit) begin
            o_d.cmp = o_q.cmp + period_i;
            o_d.idx = (o_q.idx == IDX_LAST) ? '0 : o_q.idx + IDX_ONE;
            if (o_q.idx == '0) o_d.anchor = o_q.cmp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q        <= '0;
            o_q.cmp    <= NOM;
        end else begin
            o_q        <= o_d;
        end
    end

    assign tick_o  = hit;
    assign idx_o   = o_q.idx;
    assign stamp_o = o_q.cnt;
    assign pred_o  = (o_q.idx == '0) ? o_q.cmp : o_q.anchor;
    assign win_o   = (o_q.idx == '0) || (o_q.idx == IDX_ONE);

    // Checker state: cycles since last tick and the period it promised
    logic [CNT_W-1:0] gap_q, gexp_q;
    logic [IDX_W-1:0] lidx_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            gexp_q <= NOM;
            lidx_q <= '0;
            seen_q <= 1'b0;
        end else if (tick_o) begin
            gap_q  <= CNT_ONE;
            gexp_q <= period_i;
            lidx_q <= idx_o;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + CNT_ONE;
        end
    end

    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> gap_q == gexp_q);
    p_no_missed_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= gexp_q);
    p_first_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !seen_q) |-> idx_o == '0);
    p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && seen_q) |->
            idx_o == ((lidx_q == IDX_LAST) ? '0 : lidx_q + IDX_ONE));
endmodule

// File: rtl/tick_corr.sv
module tick_corr
    import tick_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int TICKS      = 10,
    parameter int NOM_PERIOD = 500,
    parameter int PER_MIN    = 480,
    parameter int PER_MAX    = 520,
    parameter int DEAD_LIM   = 4,
    parameter int MINOR_LIM  = 80,
    parameter int GROSS_LIM  = 400,
    parameter int MINOR_STEP = 1,
    parameter int GROSS_STEP = 6,
    parameter int MOD_SHIFT  = 3,
    parameter int LOCK_N     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             win_i,
    input  logic [CNT_W-1:0] stamp_i,
    input  logic [CNT_W-1:0] pred_i,
    output logic [CNT_W-1:0] period_o,
    output logic             lock_o
);
    localparam int LCW = $clog2(LOCK_N + 1);
    localparam logic [LCW-1:0]   LMAX  = LCW'(LOCK_N);
    localparam logic [LCW-1:0]   LONE  = LCW'(1);
    localparam logic [CNT_W-1:0] PMIN  = CNT_W'(PER_MIN);
    localparam logic [CNT_W-1:0] PMAX  = CNT_W'(PER_MAX);
    localparam logic [CNT_W-1:0] PNOM  = CNT_W'(NOM_PERIOD);
    localparam logic [CNT_W-1:0] DLIM  = CNT_W'(DEAD_LIM);
    localparam logic [CNT_W-1:0] MLIM  = CNT_W'(MINOR_LIM);
    localparam logic [CNT_W-1:0] GLIM  = CNT_W'(GROSS_LIM);
    localparam logic [CNT_W-1:0] SMIN  = CNT_W'(MINOR_STEP);
    localparam logic [CNT_W-1:0] SGRS  = CNT_W'(GROSS_STEP);
    localparam logic [CNT_W-1:0] TDIV  = CNT_W'(TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic             lock;
        logic [LCW-1:0]   lcnt;
    } corr_t;

    corr_t c_d, c_q;

    logic signed [CNT_W-1:0] err;
    logic [CNT_W-1:0]        mag;
    tier_e                   tier;
    logic [CNT_W-1:0]        step;
    logic signed [CNT_W+1:0] sum;
    logic [CNT_W-1:0]        clamped;
    logic [LCW-1:0]          lnext;
    logic                    use_w;

    assign use_w = rise_i && win_i;

    always_comb begin
        err = $signed(stamp_i - pred_i);
        mag = err[CNT_W-1] ? $unsigned(-err) : $unsigned(err);

        if (mag <= DLIM)      tier = TIER_DEAD;
        else if (mag <= MLIM) tier = TIER_MINOR;
        else if (mag <= GLIM) tier = TIER_MID;
        else                  tier = TIER_GROSS;

        case (tier)
            TIER_MINOR: step = SMIN;
            TIER_MID:   step = (mag >> MOD_SHIFT) / TDIV;
            TIER_GROSS: step = SGRS;
            default:    step = '0;
        endcase

        if (err[CNT_W-1]) sum = $signed({2'b00, c_q.period}) - $signed({2'b00, step});
        else              sum = $signed({2'b00, c_q.period}) + $signed({2'b00, step});

        if (sum < $signed({2'b00, PMIN}))      clamped = PMIN;
        else if (sum > $signed({2'b00, PMAX})) clamped = PMAX;
        else                                   clamped = sum[CNT_W-1:0];

        lnext = (c_q.lcnt == LMAX) ? LMAX : c_q.lcnt + LONE;
    end

    always_comb begin
        c_d = c_q;
        if (use_w) begin
            if (tier == TIER_DEAD) begin
                c_d.lcnt = lnext;
                if (lnext == LMAX) c_d.lock = 1'b1;
            end else begin
                c_d.lcnt   = '0;
                c_d.period = clamped;
                if (tier == TIER_GROSS) c_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.period <= PNOM;
            c_q.lock   <= 1'b0;
            c_q.lcnt   <= '0;
        end else begin
            c_q        <= c_d;
        end
    end

    assign period_o = c_q.period;
    assign lock_o   = c_q.lock;

    p_period_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (period_o >= PMIN) && (period_o <= PMAX));
    p_deadband_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_w && tier == TIER_DEAD) |=> $stable(period_o));
    p_ignored_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !win_i) |=> ($stable(period_o) && $stable(lock_o)));
    p_gross_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (use_w && tier == TIER_GROSS) |=> !lock_o);
    p_lock_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(use_w && tier == TIER_DEAD));
endmodule

// File: rtl/tick_mult.sv
module tick_mult #(
    parameter int CNT_W       = 16,
    parameter int TICKS       = 10,
    parameter int NOM_PERIOD  = 500,
    parameter int PER_MIN     = 480,
    parameter int PER_MAX     = 520,
    parameter int DEAD_LIM    = 4,
    parameter int MINOR_LIM   = 80,
    parameter int GROSS_LIM   = 400,
    parameter int MINOR_STEP  = 1,
    parameter int GROSS_STEP  = 6,
    parameter int MOD_SHIFT   = 3,
    parameter int LOCK_N      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_i,
    output logic                     tick_o,
    output logic [$clog2(TICKS)-1:0] tick_idx_o,
    output logic [CNT_W-1:0]         period_o,
    output logic                     lock_o
);
    logic             rise;
    logic             win;
    logic [CNT_W-1:0] stamp;
    logic [CNT_W-1:0] pred;

    tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_i),
        .rise_o (rise)
    );

    tick_dco #(
        .CNT_W      (CNT_W),
        .TICKS      (TICKS),
        .NOM_PERIOD (NOM_PERIOD)
    ) u_dco (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_o),
        .tick_o   (tick_o),
        .idx_o    (tick_idx_o),
        .stamp_o  (stamp),
        .pred_o   (pred),
        .win_o    (win)
    );

    tick_corr #(
        .CNT_W      (CNT_W),
        .TICKS      (TICKS),
        .NOM_PERIOD (NOM_PERIOD),
        .PER_MIN    (PER_MIN),
        .PER_MAX    (PER_MAX),
        .DEAD_LIM   (DEAD_LIM),
        .MINOR_LIM  (MINOR_LIM),
        .GROSS_LIM  (GROSS_LIM),
        .MINOR_STEP (MINOR_STEP),
        .GROSS_STEP (GROSS_STEP),
        .MOD_SHIFT  (MOD_SHIFT),
        .LOCK_N     (LOCK_N)
    ) u_corr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .win_i    (win),
        .stamp_i  (stamp),
        .pred_i   (pred),
        .period_o (period_o),
        .lock_o   (lock_o)
    );

    // R1: no tick can be pending while the period is still nominal and idle
    p_reset_period_r1: assert property (@(posedge clk)
        !rst_n |=> (period_o == CNT_W'(NOM_PERIOD)) && !lock_o && !tick_o);
endmodule

// File: tb/sim_tick_mult.sv
module sim_tick_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_i = 1'b0;
    logic        tick_o;
    logic [3:0]  tick_idx_o;
    logic [15:0] period_o;
    logic        lock_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_per = 500;
    int exp_lock = 0;
    int exp_lcnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tick_mult u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (ref_i),
        .tick_o     (tick_o),
        .tick_idx_o (tick_idx_o),
        .period_o   (period_o),
        .lock_o     (lock_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idx(input int want);
        do @(negedge clk); while (!(tick_o && tick_idx_o == want[3:0]));
    endtask

    // Model of the tiered law, clamp and lock from the requirements
    task automatic model(input int e);
        int mag, st, np;
        mag = (e < 0) ? -e : e;
        if (mag <= 4)        st = 0;
        else if (mag <= 80)  st = 1;
        else if (mag <= 400) st = (mag / 8) / 10;
        else                 st = 6;
        if (mag <= 4) begin
            if (exp_lcnt < 3) exp_lcnt++;
            if (exp_lcnt == 3) exp_lock = 1;
        end else begin
            exp_lcnt = 0;
            np = (e < 0) ? exp_per - st : exp_per + st;
            if (np < 480) np = 480;
            if (np > 520) np = 520;
            exp_per = np;
            if (mag > 400) exp_lock = 0;
        end
    endtask

    // Place a reference edge whose phase error is e counts
    task automatic send_edge(input int e, input string req);
        int p;
        wait_idx(9);
        p = period_o;
        repeat (p + e - 2) @(negedge clk);
        ref_i = 1'b1;
        repeat (4) @(negedge clk);
        ref_i = 1'b0;
        model(e);
        wait_idx(3);
        check({req, " period"}, period_o, exp_per);
        check({req, " lock"}, lock_o, exp_lock);
    endtask

    task automatic t_reset_and_ticks();
        int n, last, gap;
        repeat (3) @(negedge clk);
        check("R1 tick", tick_o, 0);
        check("R1 idx", tick_idx_o, 0);
        check("R1 period", period_o, 500);
        check("R1 lock", lock_o, 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_o);
        check("R2 first tick delay", n, 500);
        check("R3 first index", tick_idx_o, 0);
        last = n;
        for (int k = 1; k <= 11; k++) begin
            int pp;
            pp = period_o;
            do begin @(negedge clk); n++; end while (!tick_o);
            gap = n - last;
            last = n;
            check("R2 tick spacing", gap, pp);
            check("R3 index sequence", tick_idx_o, k % 10);
        end
    endtask

    task automatic t_lock();
        send_edge(0, "R11 R5 zero error");
        send_edge(4, "R11 R5 deadband +4");
        send_edge(-4, "R11 R5 deadband -4");
    endtask

    task automatic t_minor();
        send_edge(30, "R6 R4 minor late");
        send_edge(-30, "R6 R4 minor early");
    endtask

    task automatic t_moderate();
        send_edge(-200, "R7 moderate early");
        send_edge(400, "R7 moderate late");
    endtask

    task automatic t_gross();
        send_edge(450, "R8 gross late");
        send_edge(-450, "R8 gross early");
    endtask

    task automatic t_ignore();
        int p0, l0;
        wait_idx(4);
        p0 = period_o;
        l0 = lock_o;
        repeat (100) @(negedge clk);
        ref_i = 1'b1;
        repeat (4) @(negedge clk);
        ref_i = 1'b0;
        wait_idx(7);
        check("R9 ignored edge period", period_o, p0);
        check("R9 ignored edge lock", lock_o, l0);
    endtask

    task automatic t_clamp();
        for (int k = 0; k < 3; k++) send_edge(450, "R10 upper clamp");
        check("R10 upper bound", period_o, 520);
        for (int k = 0; k < 7; k++) send_edge(-450, "R10 lower clamp");
        check("R10 lower bound", period_o, 480);
    endtask

    initial begin
        t_reset_and_ticks();
        t_lock();
        t_minor();
        t_moderate();
        t_gross();
        t_ignore();
        t_clamp();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 act=timeout exp=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule